// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter Stage

This block is one stage of a synchronous binary up-counter. The default width is four bits. It can be cleared, preset from a parallel data word, counted up or held. Two active-high enables must both be high for the stage to count. Only one of them, the chain enable, also gates the carry output.

Because of that split, identical stages can be joined into a wider counter. Each stage's carry output feeds the chain enable of the stage above it. The local enable is shared by all stages, so the whole chain still advances on one clock edge.

A parameter selects the clear style, and both styles use the same ports. In the asynchronous style, a low reset clears the count at once. In the synchronous style, a low reset clears the count on the next rising clock edge.

Top module: `presettable_counter`

## Requirements
- R1: The count follows a modulo-2^WIDTH binary sequence. With the default width of 4, a count step from 15 gives 0.
- R2: With ASYNC_RESET=1, a low rst_n clears count to 0 at once, without waiting for a clock edge. count stays 0 while rst_n is low, whatever the other inputs do.
- R3: With ASYNC_RESET=0, a low rst_n leaves count unchanged until the next rising clock edge. At that edge count becomes 0, even when preset_n is low and both enables are high.
- R4: While rst_n is high, a low preset_n loads preset_val into count on the next rising edge. This load takes priority over counting and ignores both enables.
- R5: When rst_n and preset_n are high and en_local and en_chain are both high, count increases by one on each rising edge.
- R6: When rst_n and preset_n are high and either enable is low, count keeps its value across the rising edge.
- R7: carry_out is combinational. It is 1 exactly when count is all ones and en_chain is 1, and en_local has no effect on it. A load of all ones with en_chain high raises carry_out right after that edge.
- R8: Two stages form an 8-bit counter when the lower stage's carry_out drives the upper stage's en_chain and en_local is shared. That counter carries across the nibble boundary and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its rising edge |
| rst_n | input | 1 | Active-low clear; asynchronous or synchronous according to ASYNC_RESET |
| preset_n | input | 1 | Active-low parallel load strobe |
| en_local | input | 1 | Count enable that does not affect carry_out |
| en_chain | input | 1 | Count enable that also gates carry_out |
| preset_val | input | WIDTH | Value loaded when preset_n is low |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | High when count is all ones and en_chain is high |

## Verification
Load, count, hold and synchronous clear all take effect at the first rising edge after the inputs are applied, because there is one register between the inputs and count. The bench drives inputs at the falling edge and samples 5 ns after the following rising edge. It checks the synchronous clear both before that edge, where the count must be unchanged, and after it.

carry_out and the asynchronous clear need no clock edge. The bench changes en_chain or rst_n in the middle of a cycle and samples a few nanoseconds later, well before the next edge.

// File: rtl/counter_pkg.sv
package counter_pkg;
  typedef enum logic [1:0] {
    MODE_CLEAR = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_STEP  = 2'd2,
    MODE_KEEP  = 2'd3
  } cnt_mode_t;
endpackage

// File: rtl/cnt_mode_sel.sv
module cnt_mode_sel
  import counter_pkg::*;
(
  input  logic      rst_n,
  input  logic      preset_n,
  input  logic      en_local,
  input  logic      en_chain,
  output cnt_mode_t mode
);
  // Fixed precedence: clear, load, step, keep.
  always_comb begin
    if (!rst_n)                      mode = MODE_CLEAR;
    else if (!preset_n)              mode = MODE_LOAD;
    else if (en_local && en_chain)   mode = MODE_STEP;
    else                             mode = MODE_KEEP;
  end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_mode_t         mode,
  input  logic [WIDTH-1:0]  q,
  input  logic [WIDTH-1:0]  din,
  output logic [WIDTH-1:0]  q_next,
  output logic              q_en
);
  always_comb begin
    q_en = (mode != MODE_KEEP);
    unique case (mode)
      MODE_CLEAR: q_next = '0;
      MODE_LOAD:  q_next = din;
      MODE_STEP:  q_next = WIDTH'(q + 1'b1);
      default:    q_next = q;
    endcase
  end
endmodule

// File: rtl/cnt_term.sv
module cnt_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_chain,
  output logic             carry
);
  always_comb carry = (&q) & en_chain;
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import counter_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preset_n,
  input  logic             en_local,
  input  logic             en_chain,
  input  logic [WIDTH-1:0] preset_val,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  cnt_mode_t        mode;
  logic [WIDTH-1:0] q, q_next;
  logic             q_en;

  cnt_mode_sel u_mode (
    .rst_n    (rst_n),
    .preset_n (preset_n),
    .en_local (en_local),
    .en_chain (en_chain),
    .mode     (mode)
  );

  cnt_next #(.WIDTH(WIDTH)) u_next (
    .mode   (mode),
    .q      (q),
    .din    (preset_val),
    .q_next (q_next),
    .q_en   (q_en)
  );

  cnt_term #(.WIDTH(WIDTH)) u_term (
    .q        (q),
    .en_chain (en_chain),
    .carry    (carry_out)
  );

  generate
    if (ASYNC_RESET) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (q_en) q <= q_next;
      end

      assert_async_clear_R2: assert property (@(posedge clk)
        !rst_n |-> q == '0);
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (q_en) q <= q_next;
      end

      assert_sync_clear_R3: assert property (@(posedge clk)
        !rst_n |=> q == '0);
    end
  endgenerate

  assign count = q;

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STEP && q == ALL_ONES) |=> q == '0);

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !preset_n |=> q == $past(preset_val));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_n && en_local && en_chain) |=> q == WIDTH'($past(q) + 1'b1));

  assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_n && !(en_local && en_chain)) |=> $stable(q));

  assert_carry_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_chain || q != ALL_ONES) |-> !carry_out);

  assert_carry_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_chain && q == ALL_ONES) |-> carry_out);
endmodule

// File: tb/sim_presettable_counter.sv
module sim_presettable_counter;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Cascaded asynchronous pair
  logic       rst_a_n, pl_n, el, ec;
  logic [7:0] din;
  logic [3:0] q_lo, q_hi;
  logic       lo_tc, hi_tc;

  // Single synchronous-clear stage
  logic       s_rst_n, s_pl_n, s_el, s_ec;
  logic [3:0] s_din, s_q;
  logic       s_tc;

  presettable_counter #(.WIDTH(4), .ASYNC_RESET(1'b1)) u0 (
    .clk(clk), .rst_n(rst_a_n), .preset_n(pl_n), .en_local(el), .en_chain(ec),
    .preset_val(din[3:0]), .count(q_lo), .carry_out(lo_tc));

  presettable_counter #(.WIDTH(4), .ASYNC_RESET(1'b1)) u1 (
    .clk(clk), .rst_n(rst_a_n), .preset_n(pl_n), .en_local(el), .en_chain(lo_tc),
    .preset_val(din[7:4]), .count(q_hi), .carry_out(hi_tc));

  presettable_counter #(.WIDTH(4), .ASYNC_RESET(1'b0)) u2 (
    .clk(clk), .rst_n(s_rst_n), .preset_n(s_pl_n), .en_local(s_el), .en_chain(s_ec),
    .preset_val(s_din), .count(s_q), .carry_out(s_tc));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {preset_n, en_local, en_chain, din[7:0], expected count[7:0], expected top carry}
  localparam logic [19:0] VEC [0:11] = '{
    {1'b0, 1'b0, 1'b0, 8'hFD, 8'hFD, 1'b0},  // R4 load ignores enables
    {1'b1, 1'b1, 1'b1, 8'h00, 8'hFE, 1'b0},  // R5
    {1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1},  // R5, R7
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0},  // R8 wrap 255
    {1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0},  // R6 local low
    {1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0},  // R6 chain low
    {1'b0, 1'b1, 1'b1, 8'h3E, 8'h3E, 1'b0},  // R4 load over count
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h3F, 1'b0},  // R5
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h40, 1'b0},  // R8 nibble carry
    {1'b1, 1'b0, 1'b0, 8'h00, 8'h40, 1'b0},  // R6
    {1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, 1'b0},  // R7 gated by chain
    {1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1}   // R7 local has no effect
  };

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_a_n = 0; pl_n = 1; el = 1; ec = 1; din = 8'h00;
    s_rst_n = 0; s_pl_n = 1; s_el = 0; s_ec = 0; s_din = 4'h0;
    repeat (3) @(posedge clk);
    #5;
    chk("R2 reset count", {q_hi, q_lo}, 8'h00);
    chk("R3 reset count", {4'h0, s_q}, 8'h00);
    chk("R7 reset carry", {7'd0, hi_tc}, 8'h00);
    @(negedge clk);
    rst_a_n = 1; s_rst_n = 1; el = 0; ec = 0;

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      pl_n = VEC[i][19]; el = VEC[i][18]; ec = VEC[i][17]; din = VEC[i][16:9];
      @(posedge clk);
      #5;
      chk($sformatf("R4/R5/R6/R8 vector %0d count", i), {q_hi, q_lo}, VEC[i][8:1]);
      chk($sformatf("R7 vector %0d carry", i), {7'd0, hi_tc}, {7'd0, VEC[i][0]});
    end

    // R2: immediate clear in mid-cycle, held through an edge with load requested
    #2 rst_a_n = 0;
    #1 chk("R2 immediate clear", {q_hi, q_lo}, 8'h00);
    @(negedge clk);
    pl_n = 0; din = 8'hAA; el = 1; ec = 1;
    @(posedge clk);
    #5 chk("R2 clear overrides load", {q_hi, q_lo}, 8'h00);
    @(negedge clk);
    rst_a_n = 1; pl_n = 0; din = 8'h0F; el = 0; ec = 1;
    @(posedge clk);
    #5 chk("R7 load of all ones raises carry", {7'd0, lo_tc}, 8'h01);
    chk("R4 load low stage", {q_hi, q_lo}, 8'h0F);
    #2 ec = 0;
    #1 chk("R7 carry follows chain enable", {7'd0, lo_tc}, 8'h00);

    // Synchronous-clear stage
    @(negedge clk);
    s_pl_n = 0; s_din = 4'hE;
    @(posedge clk);
    #5 chk("R4 sync stage load", {4'h0, s_q}, 8'h0E);
    @(negedge clk);
    s_pl_n = 1; s_el = 1; s_ec = 1;
    @(posedge clk);
    #5 chk("R5 sync stage step", {4'h0, s_q}, 8'h0F);
    chk("R7 sync stage carry", {7'd0, s_tc}, 8'h01);
    @(posedge clk);
    #5 chk("R1 wrap 15 to 0", {4'h0, s_q}, 8'h00);
    @(posedge clk);
    #5 chk("R5 step after wrap", {4'h0, s_q}, 8'h01);
    @(negedge clk);
    s_rst_n = 0; s_pl_n = 0; s_din = 4'h9;
    #3 chk("R3 no clear before edge", {4'h0, s_q}, 8'h01);
    @(posedge clk);
    #5 chk("R3 clear overrides load", {4'h0, s_q}, 8'h00);
    @(negedge clk);
    s_rst_n = 1; s_pl_n = 1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule